// File: doc/BRIEF.md
# Display Controller Command and Pixel-Byte Decoder

This block sits behind a byte-level serial receiver of a monochrome graphic display controller. Each received byte arrives with a one-cycle `byte_valid` strobe and is qualified by an active-low chip select and a data/command select line. Command bytes are decoded into the display configuration: contrast level, inversion, panel enable, column mirroring and row-scan direction. Command bytes also move a page/column write cursor. Data bytes are stored in a frame memory of `PAGES` pages by `COLS` one-byte columns. The cursor steps forward after each store.

Most opcodes take a single byte, and some are range-coded: the low bits of the opcode carry an operand. The contrast opcode opens a pending state in which the next command byte is taken as the new contrast level. A falling edge on the host-driven active-low reset line restores the configuration at once. It then starts a sweep that writes zero to every frame memory location, one location per clock. The system reset `rst` does the same. A registered read port lets a display scan engine fetch frame bytes. A sticky `dirty` flag, cleared by a one-cycle pulse, tells that engine that a redraw is due.

Top module: `oled_decoder`

## Requirements
- R1: A byte is accepted only when `byte_valid` is high, `cs_n` is low and no clear sweep is running. With `cs_n` high the byte changes no output, no frame byte and no cursor position.
- R2: An accepted byte with `dc`=1 is written to frame address page*COLS+column, where COLS=128. The column then increments. Past column 127 it wraps to 0 and the page increments, and past page 7 the page wraps to 0.
- R3: The command byte 0x81 makes the next accepted command byte (`dc`=0), whatever its value, the new `contrast`, and then ends the pending state. Data bytes in between are written normally and leave the pending state in place.
- R4: The command 0xA6 clears `inverted` and 0xA7 sets it. The command 0xAE clears `disp_on` and 0xAF sets it.
- R5: The commands 0xB0 to 0xB7 set the cursor page to bits [2:0] of the opcode.
- R6: The commands 0x00 to 0x0F replace column bits [3:0] with opcode bits [3:0]. The commands 0x10 to 0x1F replace column bits [6:4] with opcode bits [2:0]. The other column bits are kept, and opcode bit 3 of the high form is dropped.
- R7: The command 0xA0 sets `seg_normal` and 0xA1 clears it. The command 0xC0 sets `scan_normal` and 0xC8 clears it.
- R8: Any other command byte outside the pending state changes no output and no cursor position.
- R9: The cycle after a falling edge on `dev_rst_n` (or after `rst`): `contrast`=0x7F, `inverted`=0, `disp_on`=0, `seg_normal`=1, `scan_normal`=1, `dirty`=0, the cursor is at 0 and no command is pending. Within PAGES*COLS+2 cycles every frame byte reads 0.
- R10: `dirty` is set the cycle after an accepted data byte, an accepted contrast value, or any command of R4 or R7. A `dirty_clr` pulse clears it, but a set in the same cycle wins. Cursor commands do not set it.
- R11: `rd_data` shows the frame byte at `rd_addr` one clock after `rd_addr` is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high system reset |
| dev_rst_n | input | 1 | Host reset line; a falling edge reinitialises the block |
| cs_n | input | 1 | Active-low chip select |
| dc | input | 1 | 1 = data byte, 0 = command byte |
| byte_valid | input | 1 | One-cycle strobe for `byte_in` |
| byte_in | input | 8 | Received byte |
| dirty_clr | input | 1 | Clears `dirty` |
| rd_addr | input | 10 | Frame read address (page*COLS+column) |
| rd_data | output | 8 | Registered frame byte |
| contrast | output | 8 | Contrast level |
| inverted | output | 1 | Display inverted |
| disp_on | output | 1 | Panel enabled |
| seg_normal | output | 1 | Column 0 drives the first segment |
| scan_normal | output | 1 | Normal row-scan direction |
| dirty | output | 1 | Redraw needed |

## Verification
A wrong cursor does not show at once. It shows as frame bytes at the wrong addresses, which are found only when the whole frame memory is read back through the read port after a run of mixed command and data bytes. A wrong decode of a flag or contrast command shows on the configuration outputs one cycle after the byte. A lost pending state shows as a contrast value that differs from the one sent. A broken clear sweep leaves non-zero bytes that the full read-back finds.

// File: rtl/oled_dec_pkg.sv
package oled_dec_pkg;
  localparam logic [7:0] OP_CONTRAST  = 8'h81;
  localparam logic [7:0] OP_NORMAL    = 8'hA6;
  localparam logic [7:0] OP_INVERT    = 8'hA7;
  localparam logic [7:0] OP_PANEL_OFF = 8'hAE;
  localparam logic [7:0] OP_PANEL_ON  = 8'hAF;
  localparam logic [7:0] OP_SEG_NORM  = 8'hA0;
  localparam logic [7:0] OP_SEG_REV   = 8'hA1;
  localparam logic [7:0] OP_SCAN_NORM = 8'hC0;
  localparam logic [7:0] OP_SCAN_REV  = 8'hC8;
  localparam logic [4:0] OP_PAGE_HI5  = 5'b10110;
  localparam logic [3:0] OP_COLLO_HI4 = 4'h0;
  localparam logic [3:0] OP_COLHI_HI4 = 4'h1;
  localparam logic [7:0] CONTRAST_INIT = 8'h7F;

  typedef enum logic [3:0] {
    K_NONE, K_CONTRAST, K_NORMAL, K_INVERT, K_OFF, K_ON,
    K_PAGE, K_COL_LO, K_COL_HI, K_SEG_NORM, K_SEG_REV,
    K_SCAN_NORM, K_SCAN_REV
  } cmd_kind_t;

  typedef struct packed {
    logic [7:0] contrast;
    logic       inverted;
    logic       disp_on;
    logic       seg_normal;
    logic       scan_normal;
  } disp_cfg_t;
endpackage

// File: rtl/oled_cmd_decode.sv
module oled_cmd_decode
  import oled_dec_pkg::*;
(
  input  logic [7:0] op,
  output cmd_kind_t  kind
);
  always_comb begin
    kind = K_NONE;
    if (op[7:3] == OP_PAGE_HI5)       kind = K_PAGE;
    else if (op[7:4] == OP_COLLO_HI4) kind = K_COL_LO;
    else if (op[7:4] == OP_COLHI_HI4) kind = K_COL_HI;
    else begin
      case (op)
        OP_CONTRAST:  kind = K_CONTRAST;
        OP_NORMAL:    kind = K_NORMAL;
        OP_INVERT:    kind = K_INVERT;
        OP_PANEL_OFF: kind = K_OFF;
        OP_PANEL_ON:  kind = K_ON;
        OP_SEG_NORM:  kind = K_SEG_NORM;
        OP_SEG_REV:   kind = K_SEG_REV;
        OP_SCAN_NORM: kind = K_SCAN_NORM;
        OP_SCAN_REV:  kind = K_SCAN_REV;
        default:      kind = K_NONE;
      endcase
    end
  end
endmodule

// File: rtl/oled_cursor.sv
module oled_cursor #(
  parameter int PAGE_W = 3,
  parameter int COL_W  = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              home,
  input  logic              advance,
  input  logic              set_page,
  input  logic              set_lo,
  input  logic              set_hi,
  input  logic [3:0]        arg,
  output logic [PAGE_W-1:0] page,
  output logic [COL_W-1:0]  col
);
  localparam int HI_W = COL_W - 4;
  localparam logic [COL_W-1:0]  COL_LAST  = {COL_W{1'b1}};

  always_ff @(posedge clk) begin
    if (rst || home) begin
      page <= '0;
      col  <= '0;
    end else if (advance) begin
      col <= col + 1'b1;
      if (col == COL_LAST) page <= page + 1'b1;
    end else if (set_page) begin
      page <= arg[PAGE_W-1:0];
    end else if (set_lo) begin
      col[3:0] <= arg;
    end else if (set_hi) begin
      col[COL_W-1:4] <= arg[HI_W-1:0];
    end
  end
endmodule

// File: rtl/oled_frame_ram.sv
module oled_frame_ram #(
  parameter int DEPTH  = 1024,
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [7:0]        wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [7:0]        rdata
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/oled_decoder.sv
module oled_decoder
  import oled_dec_pkg::*;
#(
  parameter int PAGES = 8,
  parameter int COLS  = 128
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       dev_rst_n,
  input  logic       cs_n,
  input  logic       dc,
  input  logic       byte_valid,
  input  logic [7:0] byte_in,
  input  logic       dirty_clr,
  input  logic [9:0] rd_addr,
  output logic [7:0] rd_data,
  output logic [7:0] contrast,
  output logic       inverted,
  output logic       disp_on,
  output logic       seg_normal,
  output logic       scan_normal,
  output logic       dirty
);
  localparam int PAGE_W = $clog2(PAGES);
  localparam int COL_W  = $clog2(COLS);
  localparam int DEPTH  = PAGES * COLS;
  localparam int ADDR_W = PAGE_W + COL_W;
  localparam logic [ADDR_W-1:0] ADDR_LAST = ADDR_W'(DEPTH - 1);

  logic              dev_prev, fall, restart;
  logic              clr_active;
  logic [ADDR_W-1:0] clr_addr;
  logic              pending;
  disp_cfg_t         cfg;
  cmd_kind_t         kind;
  logic [PAGE_W-1:0] cur_page;
  logic [COL_W-1:0]  cur_col;
  logic              accept, data_wr, cmd_acc, cfg_cmd, set_dirty;
  logic              ram_we;
  logic [ADDR_W-1:0] ram_waddr;
  logic [7:0]        ram_wdata;

  // host reset line edge detect
  always_ff @(posedge clk) begin
    if (rst) dev_prev <= 1'b1;
    else     dev_prev <= dev_rst_n;
  end
  assign fall    = dev_prev & ~dev_rst_n;
  assign restart = rst | fall;

  assign accept  = byte_valid & ~cs_n & ~clr_active & ~fall;
  assign data_wr = accept & dc;
  assign cmd_acc = accept & ~dc;

  oled_cmd_decode u_dec (.op(byte_in), .kind(kind));

  oled_cursor #(.PAGE_W(PAGE_W), .COL_W(COL_W)) u_cursor (
    .clk      (clk),
    .rst      (rst),
    .home     (fall),
    .advance  (data_wr),
    .set_page (cmd_acc && !pending && kind == K_PAGE),
    .set_lo   (cmd_acc && !pending && kind == K_COL_LO),
    .set_hi   (cmd_acc && !pending && kind == K_COL_HI),
    .arg      (byte_in[3:0]),
    .page     (cur_page),
    .col      (cur_col)
  );

  // frame clear sweep
  always_ff @(posedge clk) begin
    if (restart) begin
      clr_active <= 1'b1;
      clr_addr   <= '0;
    end else if (clr_active) begin
      clr_addr <= clr_addr + 1'b1;
      if (clr_addr == ADDR_LAST) clr_active <= 1'b0;
    end
  end

  always_comb begin
    if (clr_active) begin
      ram_we    = 1'b1;
      ram_waddr = clr_addr;
      ram_wdata = 8'h00;
    end else begin
      ram_we    = data_wr;
      ram_waddr = {cur_page, cur_col};
      ram_wdata = byte_in;
    end
  end

  oled_frame_ram #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_ram (
    .clk   (clk),
    .we    (ram_we),
    .waddr (ram_waddr),
    .wdata (ram_wdata),
    .raddr (rd_addr[ADDR_W-1:0]),
    .rdata (rd_data)
  );

  // configuration registers
  always_comb begin
    cfg_cmd = 1'b0;
    case (kind)
      K_NORMAL, K_INVERT, K_OFF, K_ON,
      K_SEG_NORM, K_SEG_REV, K_SCAN_NORM, K_SCAN_REV: cfg_cmd = 1'b1;
      default: cfg_cmd = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (restart) begin
      pending <= 1'b0;
      cfg     <= '{contrast: CONTRAST_INIT, inverted: 1'b0, disp_on: 1'b0,
                   seg_normal: 1'b1, scan_normal: 1'b1};
    end else if (cmd_acc) begin
      if (pending) begin
        cfg.contrast <= byte_in;
        pending      <= 1'b0;
      end else begin
        case (kind)
          K_CONTRAST:  pending         <= 1'b1;
          K_NORMAL:    cfg.inverted    <= 1'b0;
          K_INVERT:    cfg.inverted    <= 1'b1;
          K_OFF:       cfg.disp_on     <= 1'b0;
          K_ON:        cfg.disp_on     <= 1'b1;
          K_SEG_NORM:  cfg.seg_normal  <= 1'b1;
          K_SEG_REV:   cfg.seg_normal  <= 1'b0;
          K_SCAN_NORM: cfg.scan_normal <= 1'b1;
          K_SCAN_REV:  cfg.scan_normal <= 1'b0;
          default:     ;
        endcase
      end
    end
  end

  assign set_dirty = data_wr | (cmd_acc & (pending | cfg_cmd));

  always_ff @(posedge clk) begin
    if (restart)        dirty <= 1'b0;
    else if (set_dirty) dirty <= 1'b1;
    else if (dirty_clr) dirty <= 1'b0;
  end

  assign contrast    = cfg.contrast;
  assign inverted    = cfg.inverted;
  assign disp_on     = cfg.disp_on;
  assign seg_normal  = cfg.seg_normal;
  assign scan_normal = cfg.scan_normal;
endmodule

// File: rtl/oled_decoder_chk.sv
module oled_decoder_chk (
  input logic       clk,
  input logic       rst,
  input logic       dev_rst_n,
  input logic       cs_n,
  input logic       dc,
  input logic       byte_valid,
  input logic [7:0] byte_in,
  input logic [7:0] contrast,
  input logic       inverted,
  input logic       disp_on,
  input logic       seg_normal,
  input logic       scan_normal,
  input logic       dirty,
  input logic       clr_active,
  input logic       pending
);
  logic cmd_ok;
  assign cmd_ok = byte_valid && !cs_n && !dc && !clr_active && dev_rst_n;

  assert_deselect_ignored_R1: assert property (@(posedge clk) disable iff (rst)
    byte_valid && cs_n && dev_rst_n |=>
      $stable(contrast) && $stable(inverted) && $stable(disp_on) &&
      $stable(seg_normal) && $stable(scan_normal));

  assert_invert_cmd_R4: assert property (@(posedge clk) disable iff (rst)
    cmd_ok && !pending && byte_in == 8'hA7 |=> inverted);

  assert_panel_on_R4: assert property (@(posedge clk) disable iff (rst)
    cmd_ok && !pending && byte_in == 8'hAF |=> disp_on);

  assert_contrast_load_R3: assert property (@(posedge clk) disable iff (rst)
    cmd_ok && pending |=> contrast == $past(byte_in) && !pending);

  assert_seg_rev_R7: assert property (@(posedge clk) disable iff (rst)
    cmd_ok && !pending && byte_in == 8'hA1 |=> !seg_normal);

  assert_unknown_ignored_R8: assert property (@(posedge clk) disable iff (rst)
    cmd_ok && !pending && byte_in == 8'hE3 |=>
      $stable(contrast) && $stable(inverted) && $stable(disp_on) &&
      $stable(seg_normal) && $stable(scan_normal) && !pending);

  assert_host_reset_R9: assert property (@(posedge clk) disable iff (rst)
    $fell(dev_rst_n) |=>
      contrast == 8'h7F && !inverted && !disp_on && seg_normal &&
      scan_normal && !dirty && clr_active);

  assert_dirty_cause_R10: assert property (@(posedge clk) disable iff (rst)
    $rose(dirty) |-> $past(byte_valid && !cs_n && !clr_active));
endmodule

bind oled_decoder oled_decoder_chk u_chk (
  .clk(clk), .rst(rst), .dev_rst_n(dev_rst_n), .cs_n(cs_n), .dc(dc),
  .byte_valid(byte_valid), .byte_in(byte_in), .contrast(contrast),
  .inverted(inverted), .disp_on(disp_on), .seg_normal(seg_normal),
  .scan_normal(scan_normal), .dirty(dirty), .clr_active(clr_active),
  .pending(pending)
);

// File: tb/oled_decoder_test.sv
`timescale 1ns/1ps
module oled_decoder_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       dev_rst_n = 1'b1;
  logic       cs_n = 1'b1;
  logic       dc = 1'b0;
  logic       byte_valid = 1'b0;
  logic [7:0] byte_in = 8'h00;
  logic       dirty_clr = 1'b0;
  logic [9:0] rd_addr = '0;
  logic [7:0] rd_data, contrast;
  logic       inverted, disp_on, seg_normal, scan_normal, dirty;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;

  // bench model
  logic [7:0] m_mem [1024];
  logic [2:0] m_page;
  logic [6:0] m_col;
  logic [7:0] m_con;
  logic       m_inv, m_on, m_seg, m_scan, m_pend, m_dirty;

  always #10 clk = ~clk;

  oled_decoder uut (
    .clk(clk), .rst(rst), .dev_rst_n(dev_rst_n), .cs_n(cs_n), .dc(dc),
    .byte_valid(byte_valid), .byte_in(byte_in), .dirty_clr(dirty_clr),
    .rd_addr(rd_addr), .rd_data(rd_data), .contrast(contrast),
    .inverted(inverted), .disp_on(disp_on), .seg_normal(seg_normal),
    .scan_normal(scan_normal), .dirty(dirty)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 1024; i++) m_mem[i] = 8'h00;
    m_page = 0; m_col = 0; m_con = 8'h7F;
    m_inv = 0; m_on = 0; m_seg = 1; m_scan = 1; m_pend = 0; m_dirty = 0;
  endtask

  task automatic model_byte(input logic d, input logic [7:0] b);
    if (d) begin
      m_mem[{m_page, m_col}] = b;
      if (m_col == 7'd127) m_page = m_page + 1'b1;
      m_col = m_col + 1'b1;
      m_dirty = 1;
    end else if (m_pend) begin
      m_con = b; m_pend = 0; m_dirty = 1;
    end else if (b[7:3] == 5'b10110) m_page = b[2:0];
    else if (b[7:4] == 4'h0) m_col[3:0] = b[3:0];
    else if (b[7:4] == 4'h1) m_col[6:4] = b[2:0];
    else case (b)
      8'h81: m_pend = 1;
      8'hA6: begin m_inv = 0; m_dirty = 1; end
      8'hA7: begin m_inv = 1; m_dirty = 1; end
      8'hAE: begin m_on = 0; m_dirty = 1; end
      8'hAF: begin m_on = 1; m_dirty = 1; end
      8'hA0: begin m_seg = 1; m_dirty = 1; end
      8'hA1: begin m_seg = 0; m_dirty = 1; end
      8'hC0: begin m_scan = 1; m_dirty = 1; end
      8'hC8: begin m_scan = 0; m_dirty = 1; end
      default: ;
    endcase
  endtask

  // drive on negedge, accepted at the following posedge
  task automatic send(input logic d, input logic [7:0] b, input logic csn);
    @(negedge clk);
    dc = d; byte_in = b; cs_n = csn; byte_valid = 1'b1;
    if (!csn) model_byte(d, b);
    @(negedge clk);
    byte_valid = 1'b0; cs_n = 1'b1;
  endtask

  task automatic check_cfg(input string req);
    check({req, " contrast"}, contrast, m_con);
    check({req, " inverted"}, inverted, m_inv);
    check({req, " disp_on"}, disp_on, m_on);
    check({req, " seg_normal"}, seg_normal, m_seg);
    check({req, " scan_normal"}, scan_normal, m_scan);
    check({req, " dirty"}, dirty, m_dirty);
  endtask

  task automatic read_chk(input string req, input int a);
    @(negedge clk);
    rd_addr = 10'(a);
    @(negedge clk);
    check(req, rd_data, m_mem[a]);
  endtask

  task automatic read_all(input string req);
    for (int a = 0; a < 1024; a++) read_chk(req, a);
  endtask

  task automatic wait_clear();
    repeat (1030) @(negedge clk);
  endtask

  function automatic logic [7:0] pick_cmd(input int r, input logic [7:0] x);
    case (r % 16)
      0: return 8'h81;  1: return 8'hA6;  2: return 8'hA7;  3: return 8'hAE;
      4: return 8'hAF;  5: return 8'hA0;  6: return 8'hA1;  7: return 8'hC0;
      8: return 8'hC8;  9: return {5'b10110, x[2:0]};
      10: return {4'h0, x[3:0]};  11: return {4'h1, x[3:0]};
      12: return 8'hE3; 13: return 8'hA4; 14: return 8'h3F;
      default: return x;
    endcase
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1'b1;
      errors++; checks++;
      $display("FAIL watchdog: actual %0d expected < 150000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = $urandom(32'h1306);
    model_reset();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    wait_clear();
    // R9 reset state
    check_cfg("R9 after rst");
    read_chk("R9 cleared byte", 0);
    read_chk("R9 cleared byte", 1023);

    // R2 basic data writes, R11 read latency
    send(1, 8'h5A, 0);
    send(1, 8'hC3, 0);
    read_chk("R2 R11 first byte", 0);
    read_chk("R2 second byte", 1);
    check("R10 data sets dirty", dirty, 1);

    // R10 clear, cursor commands do not set dirty
    @(negedge clk); dirty_clr = 1; @(negedge clk); dirty_clr = 0;
    m_dirty = 0;
    check("R10 cleared", dirty, 0);
    send(0, 8'hB3, 0); send(0, 8'h05, 0); send(0, 8'h12, 0);
    check("R10 cursor cmd keeps dirty low", dirty, 0);
    // R5 R6: cursor page 3, col 0x25
    send(1, 8'h77, 0);
    read_chk("R5 R6 cursor address", 3*128 + 8'h25);

    // R6 high form drops bit 3, R2 wrap corner: page 7 col 127
    send(0, 8'hB7, 0); send(0, 8'h0F, 0); send(0, 8'h1F, 0);
    send(1, 8'hE1, 0); send(1, 8'hE2, 0);
    read_chk("R2 R6 last byte", 1023);
    read_chk("R2 wrap to 0", 0);
    // column wrap increments page
    send(0, 8'hB2, 0); send(0, 8'h0F, 0); send(0, 8'h17, 0);
    send(1, 8'h91, 0); send(1, 8'h92, 0);
    read_chk("R2 column wrap", 2*128 + 127);
    read_chk("R2 next page", 3*128);

    // R1 deselected bytes ignored
    send(0, 8'hA7, 1); send(1, 8'hFF, 1);
    check_cfg("R1 deselected");
    send(1, 8'h44, 0);
    read_chk("R1 cursor unchanged", 3*128 + 1);

    // R3 pending with data in between, R4 R7 flags
    send(0, 8'h81, 0); send(1, 8'h10, 0); send(0, 8'hA7, 0);
    check("R3 contrast from next cmd", contrast, 8'hA7);
    check("R3 not inverted", inverted, 0);
    send(0, 8'hA7, 0); send(0, 8'hAF, 0); send(0, 8'hA1, 0); send(0, 8'hC8, 0);
    check_cfg("R4 R7 flags");
    // R8 unknown command
    @(negedge clk); dirty_clr = 1; @(negedge clk); dirty_clr = 0; m_dirty = 0;
    send(0, 8'hE3, 0); send(0, 8'h2E, 0);
    check_cfg("R8 unknown");

    // R10 set wins over clear in same cycle
    @(negedge clk);
    dc = 1; byte_in = 8'h3C; cs_n = 0; byte_valid = 1; dirty_clr = 1;
    model_byte(1, 8'h3C);
    @(negedge clk);
    byte_valid = 0; cs_n = 1; dirty_clr = 0;
    check("R10 set beats clear", dirty, 1);

    // random mixed stream
    for (int n = 0; n < 600; n++) begin
      int r;
      logic [7:0] x;
      r = $urandom;
      x = 8'($urandom);
      if (r[3:0] == 0) send(r[4], x, 1);
      else if (r[5]) send(1, x, 0);
      else send(0, pick_cmd(r >> 8, x), 0);
    end
    check_cfg("R3 R4 R7 R8 random");
    read_all("R2 R5 R6 random frame");

    // R9 host reset falling edge
    @(negedge clk); dev_rst_n = 0;
    @(negedge clk);
    model_reset();
    check_cfg("R9 host reset");
    wait_clear();
    dev_rst_n = 1;
    read_all("R9 frame cleared");
    send(1, 8'hAB, 0);
    read_chk("R9 cursor home", 0);

    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule